// File: doc/BRIEF.md
# Multiplexed LCD Segment Drive Controller

This block refreshes a passive LCD panel from a small on-chip display memory. The memory holds 24 words of 4 bits. Word n belongs to segment line n, and bit k of that word is the pixel where segment n crosses common line k. A counter running from a 32.768 kHz clock sets the scan step rate to one of four values. On each step the controller selects the next common line and presents the matching memory bits on every segment line. No software action is needed per frame.

Every output pin is a 2-bit code that selects one tap of an external resistor ladder. Five drive schemes trade pixel count against contrast:

- one common line (static);
- two or three lines at half bias;
- three or four lines at third bias.

The waveform polarity flips at the end of every frame, so each pixel sees no average DC. While reset is held, the pins show an all-lit test pattern. Once reset ends, the panel stays blank until a display-on pulse arrives. A display-off pulse blanks the panel again.

Top module: `lcd_mux_drv`

## Requirements
- R1: `rate_sel` values 0, 1, 2 and 3 make the scan step last 512, 256, 128 and 64 clock cycles. While the display is on, the common outputs change exactly once per step.
- R2: One frame is one step per used common line. The active common advances COM0, COM1, and so on up to the last used line, then returns to COM0. The polarity inverts on that return; in static mode it inverts on every step.
- R3: `drv_mode` encodings:
  - 0: static, one common line;
  - 1: half bias, two lines;
  - 2: half bias, three lines;
  - 3: third bias, three lines;
  - 4: third bias, four lines;
  - 5, 6 and 7: behave exactly as static.
- R4: Level codes are 0 = ground and 3 = supply. Code 1 is mid supply in half bias and one third in third bias; code 2 is two thirds. The active common is at 3 when polarity is high and 0 when low. In half bias, a used common that is not active is at 1. In third bias it is at 1 when polarity is high and 2 when low. Common lines beyond the mode's count stay at 0.
- R5: A lit segment is at 0 when polarity is high and 3 when low. An unlit segment equals the active common level in static and half bias modes. In third bias it is at 2 when polarity is high and 1 when low.
- R6: During the step that selects COMk, segment n is lit exactly when bit k of memory word n is 1.
- R7: A write with `wr_en` high and `wr_addr` from 0 to 23 stores `wr_data` at that clock edge. The new contents appear on the pins from the next scan steps, with no further action.
- R8: Writes with `wr_addr` from 24 to 31 change no memory word.
- R9: While `rst_n` is low, every common output is 0 and every segment output is 3.
- R10: After reset ends, all outputs are 0 until a display-on pulse is seen.
- R11: A `disp_off` pulse makes every output 0 from the second clock edge on. If `disp_on` and `disp_off` arrive together, off wins. A later `disp_on` pulse resumes scanning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Scan step divisor select |
| drv_mode | input | 3 | Drive scheme select |
| disp_on | input | 1 | Display-on command pulse |
| disp_off | input | 1 | Display-off command pulse |
| wr_en | input | 1 | Display memory write strobe |
| wr_addr | input | 5 | Display memory word address |
| wr_data | input | 4 | Pixel bits for COM3..COM0 |
| com_lvl | output | 8 | Common level codes, COMi in bits 2i+1:2i |
| seg_lvl | output | 48 | Segment level codes, SEGn in bits 2n+1:2n |

## Verification
The step and wrap properties assume `drv_mode` and `rate_sel` are quasi-static. They may change at any time, but the scan only regains its regular rhythm after at most one step. The bench therefore changes them only between scenarios and waits 4096 cycles before it observes anything. The one-cycle gap between divider ticks relies on the shortest step being far longer than one cycle. Commands are driven as single-cycle pulses away from the clock edge. Writes are held for exactly one cycle, so each strobe maps to a single stored word.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

   localparam int LVL_W = 2;
   typedef logic [LVL_W-1:0] lvl_t;

   // ladder tap codes
   localparam lvl_t LVL_GND  = 2'd0;
   localparam lvl_t LVL_LOW  = 2'd1;
   localparam lvl_t LVL_HIGH = 2'd2;
   localparam lvl_t LVL_TOP  = 2'd3;

   typedef enum logic [2:0] {
      MODE_STATIC = 3'd0,
      MODE_B2_D2  = 3'd1,
      MODE_B2_D3  = 3'd2,
      MODE_B3_D3  = 3'd3,
      MODE_B3_D4  = 3'd4
   } drv_mode_e;

   // index of the last common line used by a drive scheme
   function automatic logic [1:0] last_phase(input logic [2:0] mode);
      logic [1:0] r;
      case (mode)
         MODE_B2_D2:             r = 2'd1;
         MODE_B2_D3, MODE_B3_D3: r = 2'd2;
         MODE_B3_D4:             r = 2'd3;
         default:                r = 2'd0;
      endcase
      return r;
   endfunction

   function automatic logic third_bias(input logic [2:0] mode);
      return (mode == MODE_B3_D3) || (mode == MODE_B3_D4);
   endfunction

endpackage

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen #(
   parameter int BASE_SHIFT = 6,
   parameter int SEL_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] rate_sel,
   output logic             tick
);
   localparam int CNT_W = BASE_SHIFT + (2 ** SEL_W) - 1;

   if (BASE_SHIFT < 2) begin : g_bad_shift
      $error("BASE_SHIFT must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_m1;

   assign lim_m1 = {CNT_W{1'b1}} >> rate_sel;
   assign tick   = (cnt_q >= lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   // R1
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/lcd_scan_ctl.sv
module lcd_scan_ctl
   import lcd_drv_pkg::*;
#(
   parameter int PH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic [2:0]      mode,
   input  logic            on_cmd,
   input  logic            off_cmd,
   output logic [PH_W-1:0] phase,
   output logic            pol,
   output logic            disp_en
);
   logic [PH_W-1:0] last;
   assign last = PH_W'(last_phase(mode));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         pol   <= 1'b0;
      end else if (tick) begin
         if (phase >= last) begin
            phase <= '0;
            pol   <= ~pol;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       disp_en <= 1'b0;
      else if (off_cmd) disp_en <= 1'b0;
      else if (on_cmd)  disp_en <= 1'b1;
   end

   // R2
   wrap_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && phase >= last) |=> (phase == '0) && (pol != $past(pol)));

   // R2
   step_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && phase < last) |=> (phase == $past(phase) + 1'b1) && (pol == $past(pol)));

   // R1
   hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(phase) && $stable(pol));

   // R11
   off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_cmd |=> !disp_en);

   // R11
   on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (on_cmd && !off_cmd) |=> disp_en);

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
   import lcd_drv_pkg::*;
#(
   parameter int NSEG = 24,
   parameter int NCOM = 4,
   parameter int PH_W = 2
) (
   input  logic [2:0]            mode,
   input  logic [PH_W-1:0]       phase,
   input  logic                  pol,
   input  logic                  disp_en,
   input  logic [NSEG*NCOM-1:0]  pix,
   output logic [LVL_W*NCOM-1:0] com_nxt,
   output logic [LVL_W*NSEG-1:0] seg_nxt
);
   logic            third;
   logic [PH_W-1:0] last;
   lvl_t            sel_lvl, idle_lvl, on_lvl, off_lvl;

   assign third    = third_bias(mode);
   assign last     = PH_W'(last_phase(mode));
   assign sel_lvl  = pol ? LVL_TOP : LVL_GND;
   assign on_lvl   = pol ? LVL_GND : LVL_TOP;
   assign idle_lvl = third ? (pol ? LVL_LOW : LVL_HIGH) : LVL_LOW;
   assign off_lvl  = third ? (pol ? LVL_HIGH : LVL_LOW) : sel_lvl;

   for (genvar i = 0; i < NCOM; i++) begin : g_com
      localparam logic [PH_W-1:0] IDX = PH_W'(i);
      always_comb begin
         if (!disp_en || IDX > last) com_nxt[i*LVL_W +: LVL_W] = LVL_GND;
         else if (IDX == phase)      com_nxt[i*LVL_W +: LVL_W] = sel_lvl;
         else                        com_nxt[i*LVL_W +: LVL_W] = idle_lvl;
      end
   end

   for (genvar n = 0; n < NSEG; n++) begin : g_seg
      logic [NCOM-1:0] word;
      assign word = pix[n*NCOM +: NCOM];
      always_comb begin
         if (!disp_en)         seg_nxt[n*LVL_W +: LVL_W] = LVL_GND;
         else if (word[phase]) seg_nxt[n*LVL_W +: LVL_W] = on_lvl;
         else                  seg_nxt[n*LVL_W +: LVL_W] = off_lvl;
      end
   end

endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv
   import lcd_drv_pkg::*;
#(
   parameter int NSEG       = 24,
   parameter int NCOM       = 4,
   parameter int ADDR_W     = 5,
   parameter int BASE_SHIFT = 6,
   parameter int SEL_W      = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SEL_W-1:0]       rate_sel,
   input  logic [2:0]             drv_mode,
   input  logic                   disp_on,
   input  logic                   disp_off,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [NCOM-1:0]        wr_data,
   output logic [LVL_W*NCOM-1:0]  com_lvl,
   output logic [LVL_W*NSEG-1:0]  seg_lvl
);
   localparam int PH_W = $clog2(NCOM);
   localparam int AW   = $clog2(NSEG);
   localparam logic [ADDR_W-1:0] SEG_LIM = ADDR_W'(NSEG);

   if (NCOM != 4) begin : g_bad_ncom
      $error("drive scheme table needs NCOM == 4");
   end
   if (NSEG > 2 ** ADDR_W || AW > ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for NSEG");
   end

   logic                  tick, pol, disp_en;
   logic [PH_W-1:0]       phase;
   logic [NCOM-1:0]       ram [NSEG];
   logic [NSEG*NCOM-1:0]  pix;
   logic [LVL_W*NCOM-1:0] com_nxt;
   logic [LVL_W*NSEG-1:0] seg_nxt;
   logic                  wr_ok;

   assign wr_ok = wr_en && (wr_addr < SEG_LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSEG; i++) ram[i] <= '0;
      end else if (wr_ok) begin
         ram[wr_addr[AW-1:0]] <= wr_data;
      end
   end

   for (genvar n = 0; n < NSEG; n++) begin : g_flat
      assign pix[n*NCOM +: NCOM] = ram[n];
   end

   lcd_tick_gen #(.BASE_SHIFT(BASE_SHIFT), .SEL_W(SEL_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .tick(tick));

   lcd_scan_ctl #(.PH_W(PH_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode(drv_mode),
      .on_cmd(disp_on), .off_cmd(disp_off),
      .phase(phase), .pol(pol), .disp_en(disp_en));

   lcd_level_map #(.NSEG(NSEG), .NCOM(NCOM), .PH_W(PH_W)) u_map (
      .mode(drv_mode), .phase(phase), .pol(pol), .disp_en(disp_en),
      .pix(pix), .com_nxt(com_nxt), .seg_nxt(seg_nxt));

   // reset value is the all-lit test pattern
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         com_lvl <= {NCOM{LVL_GND}};
         seg_lvl <= {NSEG{LVL_TOP}};
      end else begin
         com_lvl <= com_nxt;
         seg_lvl <= seg_nxt;
      end
   end

   // R10
   dark_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_en |=> (com_lvl == '0) && (seg_lvl == '0));

   // R7
   wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> ram[$past(wr_addr[AW-1:0])] == $past(wr_data));

   // R8
   wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_ok) |=> $stable(pix));

endmodule

// File: tb/tb_lcd_mux_drv.sv
module tb_lcd_mux_drv;
   localparam int NSEG = 24;
   localparam int NCOM = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  rate_sel = 2'd3;
   logic [2:0]  drv_mode = 3'd0;
   logic        disp_on = 1'b0, disp_off = 1'b0, wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [3:0]  wr_data = '0;
   logic [7:0]  com_lvl;
   logic [47:0] seg_lvl;

   always #5 clk = ~clk;

   lcd_mux_drv dut (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .drv_mode(drv_mode),
      .disp_on(disp_on), .disp_off(disp_off), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl));

   int checks = 0;
   int errors = 0;
   logic [3:0] shadow [NSEG];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [3:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a < 5'd24) shadow[a] = d;
   endtask

   task automatic pulse(input bit on, input bit off);
      @(negedge clk);
      disp_on = on; disp_off = off;
      @(negedge clk);
      disp_on = 1'b0; disp_off = 1'b0;
   endtask

   function automatic int duty_of(input int m);
      case (m)
         1: return 2;
         2, 3: return 3;
         4: return 4;
         default: return 1;
      endcase
   endfunction

   function automatic bit third_of(input int m);
      return (m == 3) || (m == 4);
   endfunction

   function automatic logic [7:0] exp_com(input int m, input int a, input bit p);
      logic [7:0] v = '0;
      for (int i = 0; i < NCOM; i++) begin
         if (i >= duty_of(m))  v[2*i +: 2] = 2'd0;
         else if (i == a)      v[2*i +: 2] = p ? 2'd3 : 2'd0;
         else if (third_of(m)) v[2*i +: 2] = p ? 2'd1 : 2'd2;
         else                  v[2*i +: 2] = 2'd1;
      end
      return v;
   endfunction

   function automatic logic [47:0] exp_seg(input int m, input int a, input bit p);
      logic [47:0] v = '0;
      for (int n = 0; n < NSEG; n++) begin
         if (shadow[n][a])     v[2*n +: 2] = p ? 2'd0 : 2'd3;
         else if (third_of(m)) v[2*n +: 2] = p ? 2'd2 : 2'd1;
         else                  v[2*n +: 2] = p ? 2'd3 : 2'd0;
      end
      return v;
   endfunction

   // watch several steps of one drive scheme and check every one
   task automatic scan_test(input int m, input int rsel, input string seg_tag);
      int lim  = 512 >> rsel;
      int duty = duty_of(m);
      int gap = 0, steps = 0, a = 0, pa = 0, hits;
      bit p = 1'b0, pp = 1'b0, have_prev = 1'b0;
      logic [7:0] prev;
      drv_mode = 3'(m);
      rate_sel = 2'(rsel);
      cycles(4096);
      prev = com_lvl;
      while (steps < 2 * duty + 2) begin
         @(negedge clk);
         gap++;
         if (gap > 2 * lim) begin
            chk(1'b0, "R1", "no common update", 64'(gap), 64'(lim));
            break;
         end
         if (com_lvl != prev) begin
            if (have_prev) chk(gap == lim, "R1", "step length", 64'(gap), 64'(lim));
            hits = 0;
            for (int i = 0; i < duty; i++) begin
               if (com_lvl[2*i +: 2] == 2'd0 || com_lvl[2*i +: 2] == 2'd3) begin
                  hits++;
                  a = i;
               end
            end
            p = (com_lvl[2*a +: 2] == 2'd3);
            chk(hits == 1, "R4", "active common count", 64'(hits), 64'd1);
            chk(com_lvl == exp_com(m, a, p), "R4", "common levels",
                64'(com_lvl), 64'(exp_com(m, a, p)));
            chk(seg_lvl == exp_seg(m, a, p), seg_tag, "segment levels",
                64'(seg_lvl), 64'(exp_seg(m, a, p)));
            if (have_prev) begin
               chk(a == (pa + 1) % duty, "R2", "active common order", 64'(a),
                   64'((pa + 1) % duty));
               chk(p == ((pa == duty - 1) ? !pp : pp), "R2", "polarity",
                   64'(p), 64'((pa == duty - 1) ? !pp : pp));
            end
            prev = com_lvl; pa = a; pp = p;
            have_prev = 1'b1; gap = 0; steps++;
         end
      end
   endtask

   task automatic reset_test();
      rst_n = 1'b0;
      cycles(3);
      chk(com_lvl == '0, "R9", "commons during reset", 64'(com_lvl), 64'd0);
      chk(seg_lvl == {NSEG{2'd3}}, "R9", "segments during reset",
          64'(seg_lvl), 64'({NSEG{2'd3}}));
      rst_n = 1'b1;
      cycles(2);
      begin
         bit dark = 1'b1;
         for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            if (com_lvl != '0 || seg_lvl != '0) dark = 1'b0;
         end
         chk(dark, "R10", "blank after reset", 64'(dark), 64'd1);
      end
   endtask

   task automatic off_test();
      bit dark;
      drv_mode = 3'd4;
      rate_sel = 2'd3;
      cycles(600);
      chk(com_lvl != '0, "R11", "running before off", 64'(com_lvl), 64'hff);
      pulse(1'b0, 1'b1);
      cycles(2);
      dark = 1'b1;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (com_lvl != '0 || seg_lvl != '0) dark = 1'b0;
      end
      chk(dark, "R11", "blank after off", 64'(dark), 64'd1);
      pulse(1'b1, 1'b1);
      cycles(2);
      dark = 1'b1;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (com_lvl != '0 || seg_lvl != '0) dark = 1'b0;
      end
      chk(dark, "R11", "off wins over on", 64'(dark), 64'd1);
      pulse(1'b1, 1'b0);
      cycles(3);
      chk(com_lvl != '0, "R11", "resume after on", 64'(com_lvl), 64'hff);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int n = 0; n < NSEG; n++) shadow[n] = 4'd0;
      reset_test();
      for (int n = 0; n < NSEG; n++) wr(5'(n), 4'((n * 7 + 3) & 15));
      pulse(1'b1, 1'b0);
      scan_test(0, 3, "R5/R6");
      scan_test(1, 2, "R5/R6");
      scan_test(2, 1, "R5/R6");
      scan_test(3, 0, "R5/R6");
      scan_test(4, 3, "R5/R6");
      // R7: rewrite while the panel is running
      for (int n = 0; n < NSEG; n++) wr(5'(n), ~shadow[n]);
      scan_test(4, 2, "R7");
      // R3: mode 5 behaves as static
      scan_test(5, 2, "R3");
      chk(com_lvl[7:2] == '0, "R3", "unused commons in code 5", 64'(com_lvl[7:2]), 64'd0);
      off_test();
      // R8: out-of-range writes must leave the cleared memory untouched
      for (int n = 0; n < NSEG; n++) wr(5'(n), 4'd0);
      for (int a = 24; a < 32; a++) wr(5'(a), 4'hf);
      scan_test(4, 3, "R8");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule